// File: doc/BRIEF.md
# Tag-Reserving Register Status File

This block is the architectural register file of a small out-of-order core. Each entry holds a data value, a reserved flag and a producer tag. The reserved flag and tag mark an entry whose newest value is still being computed by the reservation station with that tag. The block takes one command per cycle (ALU dispatch, read, write or no-op). It also watches a single result broadcast bus that carries a valid bit, a tag and a value.

A pending entry is filled by tag match when its producer's result appears on the broadcast bus. For an ALU dispatch the block hands the chosen reservation station two source-operand descriptors, each made of a valid bit, a tag and a value. A result that is being broadcast in the dispatch cycle is forwarded straight into the descriptor. A read of a pending entry raises stall. The selection of the receiving station is made elsewhere and arrives as an input.

Top module: `tagres_regfile`

## Requirements
- R1: The command code on `cmd_op` is 0 = no-op, 1 = ALU dispatch, 2 = read, 3 = write. A no-op changes no entry, whatever `dst_idx` and `wr_data` carry.
- R2: While `rst_n` is low, and after it is released, every entry holds `RESET_VALUE` with its reserved flag clear and its tag zero.
- R3: A read of a reserved entry raises `stall` in the same cycle and drives `rd_data` to zero. `stall` is never high for any other command or for a read of an unreserved entry.
- R4: A non-stalled read drives the current value of entry `src_a_idx` on `rd_data` in the same cycle. At all other times `rd_data` is zero.
- R5: A write stores `wr_data` in entry `dst_idx` and clears its reserved flag, visible from the next cycle.
- R6: An ALU dispatch sets the reserved flag of entry `dst_idx` and loads its tag with `station_sel`, visible from the next cycle. The entry's value is left unchanged.
- R7: When `bc_valid` is high, every reserved entry whose tag equals `bc_tag` takes `bc_value` and clears its reserved flag from the next cycle. Unreserved entries and entries with another tag are not touched.
- R8: Each operand descriptor (`opa_*` for `src_a_idx`, `opb_*` for `src_b_idx`) carries the entry's tag and value, and it is valid exactly when the entry is not reserved. The only exception is R9.
- R9: If `bc_valid` is high and the source entry is reserved with a tag equal to `bc_tag`, the descriptor is valid and carries `bc_value` in that same cycle.
- R10: Retirement is applied before the command. A dispatch or write to an entry that retires in the same cycle leaves that entry as the command sets it. After a dispatch it is reserved with the new tag and holds the broadcast value. After a write it is clear and holds `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_op | input | 2 | Command code (R1) |
| src_a_idx | input | IDX_W | First source / read index |
| src_b_idx | input | IDX_W | Second source index |
| dst_idx | input | IDX_W | Destination index for dispatch or write |
| wr_data | input | DATA_W | Write data |
| station_sel | input | TAG_W | Station receiving an ALU dispatch |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Result broadcast producer tag |
| bc_value | input | DATA_W | Result broadcast value |
| stall | output | 1 | Command not accepted this cycle |
| rd_data | output | DATA_W | Read result |
| opa_valid | output | 1 | First operand ready |
| opa_tag | output | TAG_W | First operand producer tag |
| opa_value | output | DATA_W | First operand value |
| opb_valid | output | 1 | Second operand ready |
| opb_tag | output | TAG_W | Second operand producer tag |
| opb_value | output | DATA_W | Second operand value |

## Verification
The bench targets a dispatch and a retirement that hit the same entry in the same cycle. If the design applied them in the wrong order, that entry would be left unreserved and a later read would return a stale value without stalling. It broadcasts a tag that two pending entries share; a decoder that only matched one entry would leave the other reserved for good. It checks the same-cycle forwarding into both descriptors, where a missing bypass would hand the station an invalid operand whose producer has already left the bus. It also checks that a broadcast with an unrelated tag, and a no-op that carries data, leave the entries alone.

// File: rtl/tagres_pkg.sv
package tagres_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_ALU   = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

endpackage

// File: rtl/tagres_entry.sv
module tagres_entry #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W = 2,
  parameter logic [DATA_W-1:0] RESET_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  input  logic              disp_en,
  input  logic [TAG_W-1:0]  disp_tag,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ent_resvd,
  output logic [TAG_W-1:0]  ent_tag,
  output logic [DATA_W-1:0] ent_value
);

  logic              retire_hit;
  logic              upd_en;
  logic              resvd_d;
  logic [TAG_W-1:0]  tag_d;
  logic [DATA_W-1:0] value_d;

  // Retirement first, then the command on top of it.
  always_comb begin
    retire_hit = bc_valid && ent_resvd && (ent_tag == bc_tag);
    resvd_d    = ent_resvd;
    tag_d      = ent_tag;
    value_d    = ent_value;
    if (retire_hit) begin
      resvd_d = 1'b0;
      value_d = bc_value;
    end
    if (disp_en) begin
      resvd_d = 1'b1;
      tag_d   = disp_tag;
    end
    if (wr_en) begin
      resvd_d = 1'b0;
      value_d = wr_data;
    end
    upd_en = retire_hit || disp_en || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_resvd <= 1'b0;
      ent_tag   <= '0;
      ent_value <= RESET_VALUE;
    end else if (upd_en) begin
      ent_resvd <= resvd_d;
      ent_tag   <= tag_d;
      ent_value <= value_d;
    end
  end

  // R6
  dispatch_reserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |=> ent_resvd && ent_tag == $past(disp_tag));

  // R5
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !ent_resvd && ent_value == $past(wr_data));

  // R7
  retire_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && ent_resvd && ent_tag == bc_tag && !disp_en && !wr_en)
      |=> !ent_resvd && ent_value == $past(bc_value));

  // R1
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bc_valid && !disp_en && !wr_en)
      |=> $stable(ent_value) && $stable(ent_resvd) && $stable(ent_tag));

endmodule

// File: rtl/tagres_src_port.sv
module tagres_src_port #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W = 2,
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [IDX_W-1:0]  src_idx,
  input  logic              resvd_arr [NREG],
  input  logic [TAG_W-1:0]  tag_arr   [NREG],
  input  logic [DATA_W-1:0] value_arr [NREG],
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              opd_valid,
  output logic [TAG_W-1:0]  opd_tag,
  output logic [DATA_W-1:0] opd_value
);

  logic sel_resvd;
  logic fwd_hit;

  always_comb begin
    sel_resvd = resvd_arr[src_idx];
    opd_tag   = tag_arr[src_idx];
    fwd_hit   = bc_valid && sel_resvd && (opd_tag == bc_tag);
    opd_valid = !sel_resvd || fwd_hit;
    opd_value = fwd_hit ? bc_value : value_arr[src_idx];
  end

endmodule

// File: rtl/tagres_regfile.sv
module tagres_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NSTATION = 4,
  parameter logic [DATA_W-1:0] RESET_VALUE = 16'h0005,
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned TAG_W = (NSTATION > 1) ? $clog2(NSTATION) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  station_sel,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              stall,
  output logic [DATA_W-1:0] rd_data,
  output logic              opa_valid,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opa_value,
  output logic              opb_valid,
  output logic [TAG_W-1:0]  opb_tag,
  output logic [DATA_W-1:0] opb_value
);
  import tagres_pkg::*;

  cmd_e              cmd;
  logic              ent_resvd [NREG];
  logic [TAG_W-1:0]  ent_tag   [NREG];
  logic [DATA_W-1:0] ent_value [NREG];
  logic              accept;

  always_comb begin
    cmd     = cmd_e'(cmd_op);
    stall   = (cmd == CMD_READ) && ent_resvd[src_a_idx];
    accept  = !stall;
    rd_data = ((cmd == CMD_READ) && accept) ? ent_value[src_a_idx] : '0;
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
    logic disp_en;
    logic wr_en;
    always_comb begin
      disp_en = accept && (cmd == CMD_ALU)   && (dst_idx == IDX_W'(gi));
      wr_en   = accept && (cmd == CMD_WRITE) && (dst_idx == IDX_W'(gi));
    end
    tagres_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .RESET_VALUE(RESET_VALUE)
    ) u_entry (
      .clk(clk), .rst_n(rst_n),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
      .disp_en(disp_en), .disp_tag(station_sel),
      .wr_en(wr_en), .wr_data(wr_data),
      .ent_resvd(ent_resvd[gi]), .ent_tag(ent_tag[gi]), .ent_value(ent_value[gi])
    );
  end

  tagres_src_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_a (
    .src_idx(src_a_idx), .resvd_arr(ent_resvd), .tag_arr(ent_tag),
    .value_arr(ent_value), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_value(bc_value), .opd_valid(opa_valid), .opd_tag(opa_tag),
    .opd_value(opa_value)
  );

  tagres_src_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_b (
    .src_idx(src_b_idx), .resvd_arr(ent_resvd), .tag_arr(ent_tag),
    .value_arr(ent_value), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_value(bc_value), .opd_valid(opb_valid), .opd_tag(opb_tag),
    .opd_value(opb_value)
  );

  // R3
  stall_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> cmd_op == 2'd2 && ent_resvd[src_a_idx]);

  // R3
  stall_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> rd_data == '0);

  // R9
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && ent_resvd[src_a_idx] && ent_tag[src_a_idx] == bc_tag)
      |-> opa_valid && opa_value == bc_value);

  // R8
  ready_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_resvd[src_a_idx] |-> opa_valid && opa_value == ent_value[src_a_idx]);

  // R8
  pending_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_resvd[src_b_idx] && !(bc_valid && ent_tag[src_b_idx] == bc_tag))
      |-> !opb_valid && opb_tag == ent_tag[src_b_idx]);

endmodule

// File: tb/tagres_regfile_tb.sv
module tagres_regfile_tb;

  localparam int unsigned DW = 16;
  localparam logic [DW-1:0] RV = 16'h0005;

  logic          clk;
  logic          rst_n;
  logic [1:0]    cmd_op;
  logic [2:0]    src_a_idx, src_b_idx, dst_idx;
  logic [DW-1:0] wr_data;
  logic [1:0]    station_sel;
  logic          bc_valid;
  logic [1:0]    bc_tag;
  logic [DW-1:0] bc_value;
  logic          stall;
  logic [DW-1:0] rd_data;
  logic          opa_valid, opb_valid;
  logic [1:0]    opa_tag, opb_tag;
  logic [DW-1:0] opa_value, opb_value;

  int n_chk = 0;
  int n_fail = 0;

  tagres_regfile #(.NREG(8), .DATA_W(DW), .NSTATION(4), .RESET_VALUE(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .src_a_idx(src_a_idx),
    .src_b_idx(src_b_idx), .dst_idx(dst_idx), .wr_data(wr_data),
    .station_sel(station_sel), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_value(bc_value), .stall(stall), .rd_data(rd_data),
    .opa_valid(opa_valid), .opa_tag(opa_tag), .opa_value(opa_value),
    .opb_valid(opb_valid), .opb_tag(opb_tag), .opb_value(opb_value)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  a;
    logic [2:0]  b;
    logic [2:0]  d;
    logic [15:0] wd;
    logic [1:0]  sel;
    logic        bv;
    logic [1:0]  bt;
    logic [15:0] bval;
    logic        e_stall;
    logic [15:0] e_rd;
    logic        e_av;
    logic [15:0] e_aval;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 3'd1, 3'd0, 3'd1, 16'h1111, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0005},
    '{2'd2, 3'd1, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h1111, 1'b1, 16'h1111},
    '{2'd1, 3'd1, 3'd2, 3'd3, 16'h0000, 2'd2, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h1111},
    '{2'd2, 3'd3, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 16'h0005},
    '{2'd0, 3'd3, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b1, 2'd2, 16'h2222, 1'b0, 16'h0000, 1'b1, 16'h2222},
    '{2'd2, 3'd3, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h2222, 1'b1, 16'h2222},
    '{2'd1, 3'd0, 3'd0, 3'd4, 16'h0000, 2'd1, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0005},
    '{2'd1, 3'd4, 3'd4, 3'd5, 16'h0000, 2'd3, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0005},
    '{2'd0, 3'd4, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b1, 2'd3, 16'h3333, 1'b0, 16'h0000, 1'b0, 16'h0005},
    '{2'd2, 3'd5, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h3333, 1'b1, 16'h3333},
    '{2'd2, 3'd4, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 16'h0005},
    '{2'd3, 3'd4, 3'd0, 3'd4, 16'h4444, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0005},
    '{2'd2, 3'd4, 3'd0, 3'd0, 16'h0000, 2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h4444, 1'b1, 16'h4444}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one command at the falling edge, settle before sampling.
  task automatic step(input logic [1:0] op, input logic [2:0] a, input logic [2:0] b,
                      input logic [2:0] d, input logic [15:0] wd, input logic [1:0] sel,
                      input logic bv, input logic [1:0] bt, input logic [15:0] bval);
    @(negedge clk);
    cmd_op = op; src_a_idx = a; src_b_idx = b; dst_idx = d; wr_data = wd;
    station_sel = sel; bc_valid = bv; bc_tag = bt; bc_value = bval;
    #2;
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_op = 2'd0; src_a_idx = '0; src_b_idx = '0; dst_idx = '0; wr_data = '0;
    station_sel = '0; bc_valid = 1'b0; bc_tag = '0; bc_value = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "stall in reset", 32'(stall), 32'd0);
    chk("R2", "opa in reset", {15'd0, opa_valid, opa_value}, {15'd0, 1'b1, RV});
    @(negedge clk);
    rst_n = 1'b1;

    // R2: every entry reads back clean after reset
    for (int i = 0; i < 8; i++) begin
      step(2'd2, 3'(i), 3'(i), 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
      chk("R2", "reset read", {15'd0, stall, rd_data}, {15'd0, 1'b0, RV});
      chk("R2", "reset desc b", {13'd0, opb_valid, opb_tag, opb_value}, {13'd0, 1'b1, 2'd0, RV});
    end

    // R1 R3 R4 R5 R6 R7 R8 R9 R11: vector table
    for (int k = 0; k < NV; k++) begin
      step(VECS[k].op, VECS[k].a, VECS[k].b, VECS[k].d, VECS[k].wd, VECS[k].sel,
           VECS[k].bv, VECS[k].bt, VECS[k].bval);
      chk("R3", $sformatf("vec %0d stall", k), 32'(stall), 32'(VECS[k].e_stall));
      chk("R4", $sformatf("vec %0d rd_data", k), 32'(rd_data), 32'(VECS[k].e_rd));
      chk("R8", $sformatf("vec %0d opa_valid", k), 32'(opa_valid), 32'(VECS[k].e_av));
      chk("R9", $sformatf("vec %0d opa_value", k), 32'(opa_value), 32'(VECS[k].e_aval));
    end

    // R7: one broadcast retires two entries sharing a tag
    step(2'd1, 3'd0, 3'd0, 3'd6, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    step(2'd1, 3'd0, 3'd0, 3'd7, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    step(2'd0, 3'd6, 3'd7, 3'd0, 16'h0, 2'd0, 1'b1, 2'd0, 16'h7777);
    chk("R9", "dual bypass a", {15'd0, opa_valid, opa_value}, {15'd0, 1'b1, 16'h7777});
    chk("R9", "dual bypass b", {15'd0, opb_valid, opb_value}, {15'd0, 1'b1, 16'h7777});
    step(2'd2, 3'd6, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R7", "entry 6 retired", {15'd0, stall, rd_data}, {15'd0, 1'b0, 16'h7777});
    step(2'd2, 3'd7, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R7", "entry 7 retired", {15'd0, stall, rd_data}, {15'd0, 1'b0, 16'h7777});

    // R10: dispatch and retirement of the same entry in one cycle
    step(2'd1, 3'd0, 3'd0, 3'd2, 16'h0, 2'd1, 1'b0, 2'd0, 16'h0);
    step(2'd1, 3'd2, 3'd0, 3'd2, 16'h0, 2'd2, 1'b1, 2'd1, 16'hAAAA);
    chk("R9", "bypass at redispatch", {15'd0, opa_valid, opa_value}, {15'd0, 1'b1, 16'hAAAA});
    step(2'd0, 3'd2, 3'd2, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R10", "dispatch wins a", {13'd0, opa_valid, opa_tag, opa_value}, {13'd0, 1'b0, 2'd2, 16'hAAAA});
    chk("R6", "new tag on b", {29'd0, opb_valid, opb_tag}, {29'd0, 1'b0, 2'd2});
    step(2'd0, 3'd2, 3'd0, 3'd0, 16'h0, 2'd0, 1'b1, 2'd1, 16'h0BAD);
    chk("R7", "other tag ignored", {15'd0, opa_valid, opa_value}, {15'd0, 1'b0, 16'hAAAA});
    step(2'd2, 3'd2, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R10", "still reserved", {15'd0, stall, rd_data}, {15'd0, 1'b1, 16'h0});
    step(2'd0, 3'd0, 3'd0, 3'd0, 16'h0, 2'd0, 1'b1, 2'd2, 16'hBBBB);
    step(2'd2, 3'd2, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R7", "retired with new tag", {15'd0, stall, rd_data}, {15'd0, 1'b0, 16'hBBBB});

    // R10: write and retirement of the same entry in one cycle
    step(2'd1, 3'd0, 3'd0, 3'd1, 16'h0, 2'd3, 1'b0, 2'd0, 16'h0);
    step(2'd3, 3'd0, 3'd0, 3'd1, 16'hCCCC, 2'd0, 1'b1, 2'd3, 16'hDDDD);
    step(2'd2, 3'd1, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R10", "write wins", {15'd0, stall, rd_data}, {15'd0, 1'b0, 16'hCCCC});

    // R1: no-op carrying data leaves the entry alone
    step(2'd0, 3'd0, 3'd0, 3'd1, 16'hEEEE, 2'd1, 1'b0, 2'd0, 16'h0);
    step(2'd2, 3'd1, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R1", "nop ignored", {15'd0, stall, rd_data}, {15'd0, 1'b0, 16'hCCCC});

    // R9: forwarding on the second descriptor
    step(2'd1, 3'd0, 3'd0, 3'd0, 16'h0, 2'd1, 1'b0, 2'd0, 16'h0);
    step(2'd0, 3'd1, 3'd0, 3'd0, 16'h0, 2'd0, 1'b1, 2'd1, 16'h1234);
    chk("R9", "bypass b", {13'd0, opb_valid, opb_tag, opb_value}, {13'd0, 1'b1, 2'd1, 16'h1234});

    // R3: other commands never stall on a reserved source
    step(2'd1, 3'd0, 3'd0, 3'd0, 16'h0, 2'd2, 1'b0, 2'd0, 16'h0);
    step(2'd3, 3'd0, 3'd0, 3'd3, 16'h5555, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R3", "write no stall", 32'(stall), 32'd0);
    step(2'd1, 3'd0, 3'd0, 3'd6, 16'h0, 2'd3, 1'b0, 2'd0, 16'h0);
    chk("R3", "alu no stall", 32'(stall), 32'd0);
    step(2'd2, 3'd3, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    chk("R5", "write under pending", {15'd0, stall, rd_data}, {15'd0, 1'b0, 16'h5555});

    step(2'd0, 3'd0, 3'd0, 3'd0, 16'h0, 2'd0, 1'b0, 2'd0, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule